// File: doc/BRIEF.md
# Horizontal Deflection Drive Pulse Generator

This block produces the periodic pulse that drives the horizontal deflection output stage of a display back-end, together with a horizontal blanking window. The drive output is a single active-low enable for an open-drain pin. When the enable is low the pin pulls low; when it is high the pin is released. The pin is never driven high.

The block has two modes. In standby the line position advances on a 1 MHz tick, which a divide-by-five counter makes from the 5 MHz base clock. Line length and pulse width are then fixed by parameters. In normal mode the line position advances on every base clock. Software-set values give the line period, the pulse width, the phase offset of the pulse from line start, and the first and last positions of blanking. A line-start sync input restarts the line in normal mode.

All settings, including the mode select, are copied into shadow registers only at a line start. A mode change therefore never cuts a pulse short and never adds an extra one. The drive controller has four states: `ST_SB_REL` (standby, released), `ST_SB_PULL` (standby, pulling low), `ST_NM_REL` (normal, released) and `ST_NM_PULL` (normal, pulling low). On each clock it moves to the pulling state of the mode that applies next when the next line position lies inside the pulse window, and to the released state of that mode otherwise. Moving between the standby pair and the normal pair happens only on the line-start edge.

Top module: `hdrv_pulse_gen`

## Requirements
- R1: In standby the line position advances once every 5 clocks. A standby line lasts SB_PERIOD ticks, which is 80 clocks with the default of 16.
- R2: In standby the pull-low lasts exactly SB_WIDTH ticks (15 clocks by default) starting at line position 0, whatever value is on `cfg_width_i`.
- R3: In normal mode a line lasts `cfg_period_i` clocks and the pull-low lasts `cfg_width_i` clocks. `drv_pull_n_o` = 0 means pull low and 1 means released.
- R4: In normal mode a high on `line_sync_i` sampled at a clock edge sets the line position to 0 at that edge. `drv_pull_n_o` then falls `cfg_phase_i` edges later, so the pull-low starts at position `cfg_phase_i`.
- R5: A normal-mode width of 0, or a width not less than the period, is replaced by period minus one. A period below 2 is treated as 2.
- R6: In normal mode `hblank_o` rises when the position equals `cfg_blank_on_i` and falls when it equals `cfg_blank_off_i`. If the two values are equal, the fall takes priority. A window whose on value is greater than its off value wraps through the line end. In standby `hblank_o` stays high.
- R7: Writes to the configuration inputs have no effect until the next line start.
- R8: A change of `standby_i` takes effect only at a line end, and a pulse already in progress finishes at full width. On entry to standby the tick divider restarts, so the first standby pulse is also full width.
- R9: In standby `line_sync_i` is ignored and the line period stays at SB_PERIOD ticks.
- R10: Reset puts the block in standby with `drv_pull_n_o` released and `hblank_o` high. The first pull-low begins on the 5th clock edge after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | 5 MHz base clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| standby_i | input | 1 | 1 selects standby mode (applied at next line start) |
| line_sync_i | input | 1 | Line-start sync pulse, normal mode only |
| cfg_period_i | input | CNT_W | Normal-mode line period in clocks |
| cfg_width_i | input | CNT_W | Normal-mode pulse width in clocks |
| cfg_phase_i | input | CNT_W | Pulse start position within the line |
| cfg_blank_on_i | input | CNT_W | Position at which blanking asserts |
| cfg_blank_off_i | input | CNT_W | Position at which blanking deasserts |
| drv_pull_n_o | output | 1 | Open-drain enable, 0 = pull low |
| hblank_o | output | 1 | Horizontal blanking window |

## Verification
Each pulse is measured for width, for the spacing between falling edges, and for how many blanking-high clocks occur within that spacing.

- Standby runs with a nonzero width register. This separates a fixed width from a programmed one.
- Normal mode runs with a wrapping blank window and then a non-wrapping one. This separates correct wrap handling from a straight range compare.
- Width values of 0 and of exactly the period, together with phase 0, expose the clamp.
- Writes made just after a pulse starts, and mode switches made mid-pulse, show whether shadowing delays each change to the next line and whether any pulse is truncated.
- A sync pulse is tried in both modes: it restarts the line in normal mode and is ignored in standby.

// File: rtl/hdrv_pkg.sv
package hdrv_pkg;
    localparam int CNT_W = 12;

    typedef enum logic [1:0] {
        ST_SB_REL,
        ST_SB_PULL,
        ST_NM_REL,
        ST_NM_PULL
    } drv_state_e;

    typedef struct packed {
        logic             sb;
        logic [CNT_W-1:0] per;
        logic [CNT_W-1:0] wid;
        logic [CNT_W-1:0] ph;
        logic [CNT_W-1:0] bon;
        logic [CNT_W-1:0] boff;
    } line_cfg_t;
endpackage

// File: rtl/hdrv_tick_div.sv
module hdrv_tick_div #(
    parameter int DIV = 5
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic restart_i,
    output logic tick_o
);
    localparam int DW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [DW-1:0] LAST = DW'(DIV - 1);

    logic [DW-1:0] cnt_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)            cnt_q <= '0;
        else if (restart_i)     cnt_q <= '0;
        else if (cnt_q == LAST) cnt_q <= '0;
        else                    cnt_q <= cnt_q + 1'b1;
    end

    assign tick_o = (cnt_q == LAST);

    // R1: ticks are never adjacent
    p_tick_spacing_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_o |=> !tick_o);
    // R8: a restart is followed by a tick-free clock
    p_restart_clears_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        restart_i |=> !tick_o);
endmodule

// File: rtl/hdrv_line_timer.sv
module hdrv_line_timer
    import hdrv_pkg::*;
#(
    parameter int SB_PERIOD = 16,
    parameter int SB_WIDTH  = 3
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             tick_i,
    input  logic             standby_i,
    input  logic             line_sync_i,
    input  logic [CNT_W-1:0] cfg_period_i,
    input  logic [CNT_W-1:0] cfg_width_i,
    input  logic [CNT_W-1:0] cfg_phase_i,
    input  logic [CNT_W-1:0] cfg_blank_on_i,
    input  logic [CNT_W-1:0] cfg_blank_off_i,
    output logic [CNT_W-1:0] pos_nxt_o,
    output line_cfg_t        cfg_nxt_o,
    output logic             div_restart_o
);
    localparam logic [CNT_W-1:0] SB_PER_C = CNT_W'(SB_PERIOD);
    localparam logic [CNT_W-1:0] SB_WID_C = CNT_W'(SB_WIDTH);
    localparam logic [CNT_W-1:0] MIN_PER  = CNT_W'(2);
    localparam line_cfg_t SB_CFG = '{sb: 1'b1, per: SB_PER_C, wid: SB_WID_C,
                                     ph: '0, bon: '0, boff: '0};

    logic [CNT_W-1:0] pos_q;
    line_cfg_t        cfg_q;
    line_cfg_t        cfg_new;
    logic [CNT_W-1:0] per_new;
    logic             adv;
    logic             line_end;
    logic             line_start;

    always_comb begin
        per_new = (cfg_period_i < MIN_PER) ? MIN_PER : cfg_period_i;
        if (standby_i) begin
            cfg_new = SB_CFG;
        end else begin
            cfg_new.sb   = 1'b0;
            cfg_new.per  = per_new;
            cfg_new.wid  = (cfg_width_i == '0 || cfg_width_i >= per_new)
                           ? per_new - 1'b1 : cfg_width_i;
            cfg_new.ph   = cfg_phase_i;
            cfg_new.bon  = cfg_blank_on_i;
            cfg_new.boff = cfg_blank_off_i;
        end
    end

    assign adv        = cfg_q.sb ? tick_i : 1'b1;
    assign line_end   = adv && (pos_q == cfg_q.per - 1'b1);
    assign line_start = line_end || (line_sync_i && !cfg_q.sb);

    assign pos_nxt_o     = line_start ? '0 : (adv ? pos_q + 1'b1 : pos_q);
    assign cfg_nxt_o     = line_start ? cfg_new : cfg_q;
    assign div_restart_o = line_start && standby_i && !cfg_q.sb;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            pos_q <= SB_PER_C - 1'b1;
            cfg_q <= SB_CFG;
        end else begin
            pos_q <= pos_nxt_o;
            cfg_q <= cfg_nxt_o;
        end
    end

    // R8: the mode shadow only changes together with a line restart
    p_mode_at_boundary_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(cfg_q.sb) |-> pos_q == '0);
    // R5: the applied normal-mode width is inside 1..period-1
    p_width_clamped_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !cfg_q.sb |-> (cfg_q.wid != '0 && cfg_q.wid < cfg_q.per));
    // R9: sync without a tick does not move the standby line position
    p_sync_ignored_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cfg_q.sb && line_sync_i && !tick_i) |=> $stable(pos_q));
    // R7: the shadow settings hold still mid-line
    p_shadow_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pos_q != '0) |-> $stable(cfg_q));
endmodule

// File: rtl/hdrv_drive_fsm.sv
module hdrv_drive_fsm
    import hdrv_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [CNT_W-1:0] pos_nxt_i,
    input  line_cfg_t        cfg_nxt_i,
    output logic             drv_pull_n_o,
    output logic             hblank_o
);
    drv_state_e state_q, state_d;
    logic       blank_q, blank_d;
    logic       hit;

    assign hit = (pos_nxt_i >= cfg_nxt_i.ph) &&
                 ((pos_nxt_i - cfg_nxt_i.ph) < cfg_nxt_i.wid);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_SB_REL, ST_SB_PULL: begin
                if (!cfg_nxt_i.sb) state_d = hit ? ST_NM_PULL : ST_NM_REL;
                else               state_d = hit ? ST_SB_PULL : ST_SB_REL;
            end
            ST_NM_REL, ST_NM_PULL: begin
                if (cfg_nxt_i.sb)  state_d = hit ? ST_SB_PULL : ST_SB_REL;
                else               state_d = hit ? ST_NM_PULL : ST_NM_REL;
            end
            default:               state_d = ST_SB_REL;
        endcase
    end

    always_comb begin
        if (cfg_nxt_i.sb)                       blank_d = 1'b1;
        else if (pos_nxt_i == cfg_nxt_i.boff)   blank_d = 1'b0;
        else if (pos_nxt_i == cfg_nxt_i.bon)    blank_d = 1'b1;
        else                                    blank_d = blank_q;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= ST_SB_REL;
            blank_q <= 1'b1;
        end else begin
            state_q <= state_d;
            blank_q <= blank_d;
        end
    end

    always_comb begin
        drv_pull_n_o = !(state_q == ST_SB_PULL || state_q == ST_NM_PULL);
        hblank_o     = blank_q;
    end

    // R6: standby states always blank
    p_standby_blank_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_SB_REL || state_q == ST_SB_PULL) |-> hblank_o);
    // R6: reaching the off position drops blanking in normal mode
    p_blank_off_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!cfg_nxt_i.sb && pos_nxt_i == cfg_nxt_i.boff) |=> !hblank_o);
    // R4: a pull-low starts only at the phase position
    p_pull_at_phase_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(drv_pull_n_o) |-> $past(pos_nxt_i) == $past(cfg_nxt_i.ph));
endmodule

// File: rtl/hdrv_pulse_gen.sv
module hdrv_pulse_gen
    import hdrv_pkg::*;
#(
    parameter int DIV       = 5,
    parameter int SB_PERIOD = 16,
    parameter int SB_WIDTH  = 3
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             standby_i,
    input  logic             line_sync_i,
    input  logic [CNT_W-1:0] cfg_period_i,
    input  logic [CNT_W-1:0] cfg_width_i,
    input  logic [CNT_W-1:0] cfg_phase_i,
    input  logic [CNT_W-1:0] cfg_blank_on_i,
    input  logic [CNT_W-1:0] cfg_blank_off_i,
    output logic             drv_pull_n_o,
    output logic             hblank_o
);
    logic             tick;
    logic             div_restart;
    logic [CNT_W-1:0] pos_nxt;
    line_cfg_t        cfg_nxt;

    hdrv_tick_div #(.DIV(DIV)) u_div (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .restart_i (div_restart),
        .tick_o    (tick)
    );

    hdrv_line_timer #(.SB_PERIOD(SB_PERIOD), .SB_WIDTH(SB_WIDTH)) u_timer (
        .clk_i           (clk_i),
        .rst_ni          (rst_ni),
        .tick_i          (tick),
        .standby_i       (standby_i),
        .line_sync_i     (line_sync_i),
        .cfg_period_i    (cfg_period_i),
        .cfg_width_i     (cfg_width_i),
        .cfg_phase_i     (cfg_phase_i),
        .cfg_blank_on_i  (cfg_blank_on_i),
        .cfg_blank_off_i (cfg_blank_off_i),
        .pos_nxt_o       (pos_nxt),
        .cfg_nxt_o       (cfg_nxt),
        .div_restart_o   (div_restart)
    );

    hdrv_drive_fsm u_fsm (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .pos_nxt_i    (pos_nxt),
        .cfg_nxt_i    (cfg_nxt),
        .drv_pull_n_o (drv_pull_n_o),
        .hblank_o     (hblank_o)
    );

    // R10: the pin is released throughout reset recovery of the first cycle
    p_release_after_reset_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(rst_ni) |-> drv_pull_n_o);
endmodule

// File: tb/hdrv_pulse_gen_test.sv
module hdrv_pulse_gen_test;
    import hdrv_pkg::*;

    typedef struct {
        int    w;
        int    g;
        int    b;
        string req;
    } item_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic standby = 1'b1;
    logic sync = 1'b0;
    logic [CNT_W-1:0] per = 12'd40, wid = 12'd7, ph = 12'd10, bon = 12'd30, boff = 12'd5;
    logic pull_n, hblank;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    item_t q[$];
    event fall_ev;

    always #4 clk = ~clk;

    hdrv_pulse_gen uut (
        .clk_i(clk), .rst_ni(rst_n), .standby_i(standby), .line_sync_i(sync),
        .cfg_period_i(per), .cfg_width_i(wid), .cfg_phase_i(ph),
        .cfg_blank_on_i(bon), .cfg_blank_off_i(boff),
        .drv_pull_n_o(pull_n), .hblank_o(hblank)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic push(input int w, input int g, input int b, input string r);
        item_t it;
        it.w = w; it.g = g; it.b = b; it.req = r;
        q.push_back(it);
    endtask

    task automatic drain();
        wait (q.size() == 0);
    endtask

    // monitor: measures each pull-low pulse and compares with the scoreboard
    always @(posedge clk) cyc <= cyc + 1;

    logic last_n = 1'b1;
    bit   have_fall = 1'b0;
    int   last_fall = 0, wcnt = 0, bcnt = 0, gap_l = -1, bcnt_l = -1;

    always @(negedge clk) begin
        if (rst_n) begin
            if (last_n && !pull_n) begin
                gap_l  = have_fall ? cyc - last_fall : -1;
                bcnt_l = have_fall ? bcnt : -1;
                have_fall = 1'b1;
                last_fall = cyc;
                bcnt = 0;
                wcnt = 0;
                -> fall_ev;
            end
            if (!pull_n) wcnt++;
            if (hblank) bcnt++;
            if (!last_n && pull_n && q.size() > 0) begin
                item_t e;
                e = q.pop_front();
                chk(wcnt == e.w, e.req, "pulse width", wcnt, e.w);
                if (e.g >= 0) chk(gap_l == e.g, e.req, "fall spacing", gap_l, e.g);
                if (e.b >= 0) chk(bcnt_l == e.b, e.req, "blank clocks", bcnt_l, e.b);
            end
            last_n = pull_n;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        int n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R10: released and blanked, first pull-low on 5th edge (R1 divider)
        n = 0;
        do begin
            @(posedge clk);
            n++;
            @(negedge clk);
            if (n == 1) begin
                chk(pull_n == 1'b1, "R10", "released after reset", pull_n, 1);
                chk(hblank == 1'b1, "R10", "blank after reset", hblank, 1);
            end
        end while (pull_n && n < 50);
        chk(n == 5, "R10", "edges to first pull", n, 5);

        // R1, R2: standby period 80 clocks, width fixed 15 despite width reg 7
        push(15, -1, -1, "R2");
        push(15, 80, 80, "R1");
        push(15, 80, 80, "R2");
        drain();

        // R3, R7: switch to normal mode; applies at next line
        @(fall_ev);
        standby = 1'b0; per = 12'd40; wid = 12'd6; ph = 12'd10; bon = 12'd30; boff = 12'd5;
        push(15, -1, -1, "R7");
        push(6, -1, -1, "R3");
        push(6, 40, 15, "R3");
        push(6, 40, 15, "R6");
        drain();

        // R7: a width write just after a fall affects the next line only
        @(fall_ev);
        wid = 12'd9;
        push(6, 40, 15, "R7");
        push(9, 40, 15, "R7");
        push(9, 40, 15, "R3");
        drain();

        // R6: non-wrapping blank window 12..19
        @(fall_ev);
        bon = 12'd12; boff = 12'd20;
        push(9, 40, 15, "R6");
        push(9, 40, -1, "R6");
        push(9, 40, -1, "R6");
        push(9, 40, 8, "R6");
        drain();

        // R5: zero width clamps to period-1 (phase 0)
        @(fall_ev);
        wid = 12'd0; ph = 12'd0;
        push(9, 40, 8, "R5");
        push(39, 30, 8, "R5");
        push(39, 40, 8, "R5");
        drain();

        // R5: width equal to the period also clamps
        @(fall_ev);
        wid = 12'd40;
        push(39, 40, 8, "R5");
        push(39, 40, 8, "R5");
        push(39, 40, 8, "R5");
        drain();

        // R4: phase offset restored, then a sync restarts the line
        @(fall_ev);
        wid = 12'd6; ph = 12'd10;
        push(39, 40, 8, "R4");
        push(6, 50, 8, "R4");
        push(6, 40, 8, "R4");
        drain();
        repeat (4) @(negedge clk);
        sync = 1'b1;
        n = 0;
        do begin
            @(posedge clk);
            n++;
            @(negedge clk);
            sync = 1'b0;
        end while (pull_n && n < 60);
        chk(n == 11, "R4", "edges from sync to pull", n, 11);

        // R8: standby request mid-pulse; R9: sync in standby ignored
        @(fall_ev);
        standby = 1'b1;
        push(6, -1, -1, "R8");
        push(15, -1, -1, "R8");
        push(15, 80, 80, "R8");
        push(15, 80, 80, "R9");
        push(15, 80, 80, "R9");
        wait (q.size() == 2);
        repeat (7) @(negedge clk);
        sync = 1'b1;
        @(negedge clk);
        sync = 1'b0;
        drain();

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule